// File: doc/BRIEF.md
# Page-Mode DRAM Row/Column Sequencer

This block sits between a single-bit memory client and a multiplexed-address DRAM array of 256 rows by 256 columns. A client presents a 16-bit address, a write flag and one data bit on a valid/ready request port. The block splits the address into a row (upper byte) and a column (lower byte) and shares one 8-bit address bus between them. It lowers RAS to pull a whole row into the array's column latches, then lowers CAS to read or overwrite one latch. Raising RAS writes the latched row back into its cells, because sensing a row wipes them.

After an access the row stays open. A later request to the same row costs only a CAS cycle. A request to another row first closes the open one with a rewrite interval and then opens the new row. A refresh timer marks one row due every `REF_GAP` clocks, walking rows 0 through 255 in order. When a refresh is due, the block lets the current access finish, closes any open row, and runs a RAS-only cycle on the next refresh row. The request port is held off until that is done.

Request back-pressure: the client holds address, write flag and data steady while `req_valid` is high, and the request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while an access or a refresh is in progress and whenever a refresh is due. Only one request is in flight at a time. A read answers with a one-cycle `rsp_valid` pulse that cannot be stalled. A write gives no response.

Top module: `pgdram_ctrl`

## Requirements
- R1: The row is `req_addr[15:8]` and the column is `req_addr[7:0]`. `dram_addr` carries the row when RAS falls and the column when CAS falls. Refresh cycles carry the refresh row.
- R2: When a row is opened, RAS is low with CAS high for exactly `ROW_CYC` (5) cycles before CAS falls. Every CAS strobe is low for exactly one cycle.
- R3: A read returns the bit held at its address on `rsp_rdata`, with `rsp_valid` high for a single cycle. A write never raises `rsp_valid`.
- R4: A write stores `req_wdata` at its address, and `dram_we_n` is low only during the CAS strobe of a write. A later read of that address returns the bit written, across row changes and refreshes.
- R5: After an access the row stays open with RAS low. A request to the open row starts a CAS strobe on the next cycle with no new RAS fall. `req_ready` returns `PAGE_CYC` (3) cycles after that request is accepted.
- R6: Before any RAS fall, RAS has been high for at least `REWR_CYC` (3) cycles. A request to a row other than the open one first raises RAS for the rewrite.
- R7: Refreshes are RAS-only cycles on rows 0, 1, … 255, 0, … in order, one due every `REF_GAP` cycles. No row goes longer than 256·`REF_GAP` plus a small service margin without a rewrite. Every due refresh is started before the next one falls due.
- R8: While a RAS cycle is still in its row phase (no CAS yet in this RAS cycle), `req_ready` is low. A due refresh takes precedence over a waiting request.
- R9: After reset RAS, CAS and `dram_we_n` are high, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 16 | Bit address, row in the upper byte |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 1 | Read data bit |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data to the array |
| dram_dout | input | 1 | Data from the array |

## Verification
The collision that matters is a refresh falling due at the moment a request is offered, or while a row is open or being opened. The bench provokes it by streaming back-to-back page hits and row misses with a short refresh gap, so refresh ticks land in every phase of an access. A behavioural array that wipes a row when it is sensed and restores it only on RAS rise judges the outcome: lost rewrites or mistimed strobes show up as wrong read data. The bench also checks that `req_ready` stays low during every row phase, that refresh rows advance strictly in order, and that the age of every row stays inside the bound.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // no row open, RAS high
    ST_OPEN,   // row held open, waiting for work
    ST_ROW,    // RAS low, row phase
    ST_COL,    // CAS strobe
    ST_REC,    // CAS recovery
    ST_PRE     // RAS high, row being rewritten
  } seq_st_e;

  typedef enum logic [1:0] {
    NX_NONE,
    NX_ACC,
    NX_REF
  } after_pre_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgdram_refresh.sv
module pgdram_refresh #(
  parameter int ROW_W   = 8,
  parameter int REF_GAP = 390
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_ack,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TW = $clog2(REF_GAP);

  logic [TW-1:0] tcnt;
  logic          tick;

  assign tick = (tcnt == TW'(REF_GAP - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt     <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      tcnt     <= tick ? '0 : tcnt + 1'b1;
      ref_pend <= tick | (ref_pend & ~ref_ack);
      if (ref_ack) ref_row <= ref_row + 1'b1;
    end
  end

  // R7: a new tick never lands on an unserved one
  assert_tick_served_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ref_pend) |-> ref_ack);

endmodule

// File: rtl/pgdram_seq.sv
module pgdram_seq
  import pgdram_pkg::*;
#(
  parameter int ROW_W    = 8,
  parameter int ROW_CYC  = 5,
  parameter int PAGE_CYC = 3,
  parameter int REWR_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2*ROW_W-1:0] req_addr,
  input  logic               req_we,
  input  logic               req_wdata,
  output logic               rsp_valid,
  output logic               rsp_rdata,
  input  logic               ref_pend,
  input  logic [ROW_W-1:0]   ref_row,
  output logic               ref_ack,
  output logic [ROW_W-1:0]   dram_addr,
  output logic               dram_ras_n,
  output logic               dram_cas_n,
  output logic               dram_we_n,
  output logic               dram_din,
  input  logic               dram_dout
);
  localparam int MAXC = imax(imax(ROW_CYC, PAGE_CYC), REWR_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  seq_st_e          st;
  after_pre_e       nxt;
  logic [CW-1:0]    cnt;
  logic [ROW_W-1:0] open_row, cur_row, cur_col, ref_row_q;
  logic             cur_we, cur_wd, do_ref;
  logic [ROW_W-1:0] req_row, req_col;
  logic             accept;

  assign req_row   = req_addr[2*ROW_W-1:ROW_W];
  assign req_col   = req_addr[ROW_W-1:0];
  assign req_ready = ((st == ST_IDLE) || (st == ST_OPEN)) && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign ref_ack   = ((st == ST_IDLE) && ref_pend) ||
                     ((st == ST_PRE) && (cnt == '0) && (nxt == NX_REF));

  // strobes decoded straight from the state register
  assign dram_ras_n = (st == ST_IDLE) || (st == ST_PRE);
  assign dram_cas_n = (st != ST_COL);
  assign dram_we_n  = !((st == ST_COL) && cur_we);
  assign dram_din   = cur_wd;
  assign dram_addr  = (st == ST_COL) ? cur_col : (do_ref ? ref_row_q : cur_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      nxt       <= NX_NONE;
      cnt       <= '0;
      open_row  <= '0;
      cur_row   <= '0;
      cur_col   <= '0;
      ref_row_q <= '0;
      cur_we    <= 1'b0;
      cur_wd    <= 1'b0;
      do_ref    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        cur_row <= req_row;
        cur_col <= req_col;
        cur_we  <= req_we;
        cur_wd  <= req_wdata;
      end
      unique case (st)
        ST_IDLE: begin
          if (ref_pend) begin
            st        <= ST_ROW;
            do_ref    <= 1'b1;
            ref_row_q <= ref_row;
            cnt       <= CW'(ROW_CYC - 1);
          end else if (accept) begin
            st     <= ST_ROW;
            do_ref <= 1'b0;
            cnt    <= CW'(ROW_CYC - 1);
          end
        end
        ST_OPEN: begin
          if (ref_pend) begin
            st  <= ST_PRE;
            nxt <= NX_REF;
            cnt <= CW'(REWR_CYC - 1);
          end else if (accept) begin
            if (req_row == open_row) begin
              st <= ST_COL;
            end else begin
              st  <= ST_PRE;
              nxt <= NX_ACC;
              cnt <= CW'(REWR_CYC - 1);
            end
          end
        end
        ST_ROW: begin
          if (cnt == '0) begin
            if (do_ref) begin
              st  <= ST_PRE;
              nxt <= NX_NONE;
              cnt <= CW'(REWR_CYC - 1);
            end else begin
              st       <= ST_COL;
              open_row <= cur_row;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_COL: begin
          st  <= ST_REC;
          cnt <= CW'(PAGE_CYC - 2);
        end
        ST_REC: begin
          if (cnt == '0) begin
            st        <= ST_OPEN;
            rsp_valid <= !cur_we;
            rsp_rdata <= dram_dout;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PRE: begin
          if (cnt == '0) begin
            unique case (nxt)
              NX_ACC: begin
                st     <= ST_ROW;
                do_ref <= 1'b0;
                cnt    <= CW'(ROW_CYC - 1);
              end
              NX_REF: begin
                st        <= ST_ROW;
                do_ref    <= 1'b1;
                ref_row_q <= ref_row;
                cnt       <= CW'(ROW_CYC - 1);
              end
              default: st <= ST_IDLE;
            endcase
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // strobe-width trackers used only by the checks below
  logic [CW-1:0] ras_lo_cnt, ras_hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_lo_cnt <= '0;
      ras_hi_cnt <= CW'(REWR_CYC);
    end else begin
      if (dram_ras_n) ras_lo_cnt <= '0;
      else if (ras_lo_cnt < CW'(MAXC)) ras_lo_cnt <= ras_lo_cnt + 1'b1;
      if (!dram_ras_n) ras_hi_cnt <= '0;
      else if (ras_hi_cnt < CW'(MAXC)) ras_hi_cnt <= ras_hi_cnt + 1'b1;
    end
  end

  assert_row_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (ras_lo_cnt >= CW'(ROW_CYC)));

  assert_cas_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |=> dram_cas_n);

  assert_rewrite_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ras_hi_cnt >= CW'(REWR_CYC)));

  assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_page_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_OPEN) && accept && (req_row == open_row)) |=>
      (!dram_cas_n && !dram_ras_n && $stable(dram_ras_n)));

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int ROW_CYC  = 5,
  parameter int PAGE_CYC = 3,
  parameter int REWR_CYC = 3,
  parameter int REF_GAP  = 390
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_we,
  input  logic                req_wdata,
  output logic                rsp_valid,
  output logic                rsp_rdata,
  output logic [ADDR_W/2-1:0] dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_din,
  input  logic                dram_dout
);
  localparam int ROW_W = ADDR_W / 2;

  logic             ref_pend, ref_ack;
  logic [ROW_W-1:0] ref_row;

  pgdram_refresh #(
    .ROW_W   (ROW_W),
    .REF_GAP (REF_GAP)
  ) u_refresh (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_ack  (ref_ack),
    .ref_pend (ref_pend),
    .ref_row  (ref_row)
  );

  pgdram_seq #(
    .ROW_W    (ROW_W),
    .ROW_CYC  (ROW_CYC),
    .PAGE_CYC (PAGE_CYC),
    .REWR_CYC (REWR_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_we     (req_we),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .ref_pend   (ref_pend),
    .ref_row    (ref_row),
    .ref_ack    (ref_ack),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_din   (dram_din),
    .dram_dout  (dram_dout)
  );

  // R8: refresh wins over a waiting request
  assert_refresh_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && req_valid) |-> !req_ready);

endmodule

// File: tb/pgdram_ctrl_bench.sv
module pgdram_ctrl_bench;
  localparam int ROW_W    = 8;
  localparam int ROWS     = 256;
  localparam int ROW_CYC  = 5;
  localparam int PAGE_CYC = 3;
  localparam int REWR_CYC = 3;
  localparam int REF_GAP  = 40;
  localparam int LIMIT    = ROWS * REF_GAP + 32;
  localparam int WDOG     = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic        req_wdata = 1'b0;
  logic        rsp_valid, rsp_rdata;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_din, dram_dout;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pgdram_ctrl #(
    .ADDR_W(16), .ROW_CYC(ROW_CYC), .PAGE_CYC(PAGE_CYC),
    .REWR_CYC(REWR_CYC), .REF_GAP(REF_GAP)
  ) u_pgdram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_din(dram_din), .dram_dout(dram_dout)
  );

  // behavioural array: sensing a row wipes it, RAS rise restores it
  logic [ROWS-1:0] cells [ROWS];
  logic [ROWS-1:0] latch;
  logic [7:0]      m_row;
  logic            m_pras = 1'b1, m_pcas = 1'b1, m_dout = 1'b0;
  assign dram_dout = m_dout;

  initial for (int r = 0; r < ROWS; r++) cells[r] = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pras <= 1'b1;
      m_pcas <= 1'b1;
    end else begin
      m_pras <= dram_ras_n;
      m_pcas <= dram_cas_n;
      if (m_pras && !dram_ras_n) begin
        latch <= cells[dram_addr];
        cells[dram_addr] <= ~cells[dram_addr];
        m_row <= dram_addr;
      end
      if (!m_pras && dram_ras_n) cells[m_row] <= latch;
      if (m_pcas && !dram_cas_n) begin
        m_dout <= latch[dram_addr];
        if (!dram_we_n) latch[dram_addr] <= dram_din;
      end
    end
  end

  task automatic check(input logic ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic patt(input logic [15:0] a, input logic s);
    return (^(a & 16'hB5C3)) ^ s;
  endfunction

  // port monitor, sampled mid-cycle
  int   lo_run = 0, hi_run = 1000, access_opens = 0, ref_done = 0;
  logic cas_seen = 1'b0, p_ras = 1'b1, p_cas = 1'b1;
  logic [7:0] fall_row = '0, exp_ref = '0;
  int   last_rw [ROWS];

  initial for (int r = 0; r < ROWS; r++) last_rw[r] = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cyc > WDOG) begin
        check(1'b0, "watchdog", cyc, WDOG);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
      if (!dram_ras_n && p_ras) begin
        check(hi_run >= REWR_CYC, "R6 rewrite gap before RAS fall", hi_run, REWR_CYC);
        fall_row = dram_addr;
      end
      if (!dram_cas_n && !p_cas) check(1'b0, "R2 CAS wider than one cycle", 2, 1);
      if (!dram_cas_n && p_cas && !cas_seen) begin
        check(lo_run == ROW_CYC, "R2 row phase length", lo_run, ROW_CYC);
        access_opens++;
        cas_seen = 1'b1;
      end
      if (!dram_cas_n) check(!dram_ras_n, "R2 CAS outside RAS", 1, 0);
      if (!dram_we_n) check(!dram_cas_n, "R4 write enable outside CAS", 1, 0);
      if (!dram_ras_n && dram_cas_n && !cas_seen) begin
        lo_run++;
        check(!req_ready, "R8 ready during row phase", req_ready, 0);
      end
      if (dram_ras_n && !p_ras) begin
        if (!cas_seen) begin
          check(fall_row == exp_ref, "R7 refresh row order", fall_row, exp_ref);
          exp_ref = fall_row + 8'd1;
          ref_done++;
        end
        last_rw[fall_row] = cyc;
        lo_run = 0;
        cas_seen = 1'b0;
      end
      hi_run = dram_ras_n ? hi_run + 1 : 0;
      p_ras = dram_ras_n;
      p_cas = dram_cas_n;
      if (cyc % 512 == 0) begin
        int worst;
        worst = 0;
        for (int r = 0; r < ROWS; r++)
          if (cyc - last_rw[r] > worst) worst = cyc - last_rw[r];
        check(worst <= LIMIT, "R7 row age bound", worst, LIMIT);
      end
    end
  end

  task automatic issue(input logic [15:0] a, input logic we, input logic wd);
    @(negedge clk);
    req_addr = a; req_we = we; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic wd);
    logic quiet;
    issue(a, 1'b1, wd);
    quiet = 1'b1;
    while (!req_ready) begin
      if (rsp_valid) quiet = 1'b0;
      @(negedge clk);
    end
    if (rsp_valid) quiet = 1'b0;
    check(quiet, "R3 write raised rsp_valid", !quiet, 0);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic exp, input string tag);
    int n;
    issue(a, 1'b0, 1'b0);
    n = 0;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    check(rsp_valid, {tag, " read response"}, rsp_valid, 1);
    check(rsp_rdata == exp, {tag, " read data"}, rsp_rdata, exp);
  endtask

  initial begin
    logic [7:0]  rows3 [3];
    logic [15:0] a;
    int k, opens0;
    rows3[0] = 8'h00; rows3[1] = 8'h5A; rows3[2] = 8'hFF;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(dram_ras_n && dram_cas_n && dram_we_n, "R9 strobes idle after reset",
          {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    check(!rsp_valid, "R9 rsp_valid low after reset", rsp_valid, 0);
    check(req_ready, "R9 ready after reset", req_ready, 1);

    // R1 R4 R5: whole rows, page-mode streams
    foreach (rows3[i])
      for (int c = 0; c < 256; c++) begin
        a = {rows3[i], 8'(c)};
        wr(a, patt(a, 1'b0));
      end
    foreach (rows3[i])
      for (int c = 255; c >= 0; c--) begin
        a = {rows3[i], 8'(c)};
        rd_chk(a, patt(a, 1'b0), "R1 R4 R5 row sweep");
      end

    // R6: every access changes row
    for (int j = 0; j < 256; j++) begin
      a = {8'(j), 8'(j * 37)};
      wr(a, patt(a, 1'b1));
    end
    for (int j = 0; j < 256; j++) begin
      a = {8'(j), 8'(j * 37)};
      rd_chk(a, patt(a, 1'b1), "R6 row-miss sweep");
    end

    // R5: page-hit timing right after a refresh
    k = ref_done;
    while (ref_done == k) @(negedge clk);
    wr(16'h3310, 1'b1);
    opens0 = access_opens;
    issue(16'h3310, 1'b0, 1'b0);
    k = 1;
    while (!req_ready && k < 50) begin @(negedge clk); k++; end
    check(k == PAGE_CYC + 1, "R5 page-hit cycle", k - 1, PAGE_CYC);
    check(rsp_valid && rsp_rdata, "R3 R5 page-hit read data", rsp_rdata, 1);
    check(access_opens == opens0, "R5 no RAS for page hit", access_opens - opens0, 0);

    // R7: data kept across two full refresh passes
    k = ref_done;
    repeat (2 * ROWS * REF_GAP) @(negedge clk);
    check(ref_done - k >= 2 * ROWS - 2, "R7 refresh count", ref_done - k, 2 * ROWS);
    for (int j = 0; j < 256; j++) begin
      a = {8'(j), 8'(j * 37)};
      rd_chk(a, patt(a, 1'b1), "R7 retention");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule